// File: doc/BRIEF.md
# Sync-Relative Raster Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes of a raster display, together with the column and row of the current active pixel. Two counters, one per axis, restart at zero on the first cycle of each sync pulse. Every programmed position is measured from that sync edge: the sync width, the start and end of the active window, and the full line or frame length.

Software programs the block through a small word-addressed register port with a write strobe and a combinational read path. Timing writes land in a pending copy and do nothing to the live raster. Setting the commit bit arms a transfer. The transfer happens at the clock edge where both counters roll back to zero, so a frame never mixes old and new settings. The commit bit reads back as 1 until the transfer is done. Output polarities and a standby control act at once and are not held back by the commit. A one-cycle pulse marks each new frame. A second one-cycle pulse reports that a committed set of settings has taken effect.

Top module: `sync_timing_gen`

## Requirements
- R1: After reset both counters are 0. The line counter advances every clock and wraps to 0 after `line_total` cycles. The row counter advances when the line counter wraps and returns to 0 after `frame_total` lines, so a frame lasts `line_total * frame_total` cycles.
- R2: Raw hsync is active while the line counter is below the horizontal sync width. Raw vsync is active while the row counter is below the vertical sync width.
- R3: Raw data-enable is active when `h_start <= line counter < h_end` and `v_start <= row counter < v_end`. While it is active, `pos_x_o`/`pos_y_o` give the counter minus the matching start. Otherwise both are 0.
- R4: Each axis has two pending registers. Horizontal uses 0x010 and 0x014, vertical uses 0x018 and 0x01C. The first register packs the sync width in bits 12:0 and the total in bits 28:16. The second packs the active start in bits 28:16 and the active end in bits 12:0. Reads return the pending copy, and writes leave the live timing unchanged until a commit.
- R5: Writing 1 to bit 0 of 0x000 arms a commit. The pending copy becomes live at the edge where both counters wrap to 0. Bit 0 of 0x000 reads 1 while a commit is armed and 0 once it has been taken.
- R6: `cfg_taken_o` is high for exactly the first cycle in which the newly committed settings drive the outputs.
- R7: `frame_start_o` is high for one cycle each time both counters wrap to 0.
- R8: The control register at 0x004 holds the polarity bits: bit 0 hsync, bit 1 vsync, bit 2 data-enable, bit 3 pixel clock. A set bit inverts that output. Bit 3 appears directly on `pclk_inv_o`.
- R9: Bit 22 of 0x004 is standby. While it is set, both counters hold at 0 and sync and data-enable sit at their inactive levels after polarity is applied. Both positions read 0 and no frame pulse occurs. Clearing the bit restarts the raster at the first cycle of sync.
- R10: A commit armed during standby takes effect on the next clock edge, because the counters already sit at the frame origin.
- R11: A write of 0 to bit 0 of 0x000 arms nothing. A write to an unmapped address changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable after polarity |
| pclk_inv_o | output | 1 | Pixel clock inversion select |
| pos_x_o | output | CNT_W | Active column, 0 outside the active area |
| pos_y_o | output | CNT_W | Active row, 0 outside the active area |
| frame_start_o | output | 1 | One-cycle pulse at each frame origin |
| cfg_taken_o | output | 1 | One-cycle pulse when committed settings go live |

## Verification
A line counter that steps or wraps wrongly shows up within one line as a shifted hsync edge or a wrong `pos_x_o`. A wrong row counter shows up at the next line boundary in vsync and data-enable. A commit that is lost or taken early appears by the first frame origin: `cfg_taken_o` is missing or out of place, and the line length no longer matches the new total. Each cycle, the bench compares every output against a cycle-stepped model of the requirements. It also reads back the pending registers and the commit flag at the points where they must change.

// File: rtl/stg_pkg.sv
package stg_pkg;
   localparam int FIELD_W      = 13;
   localparam int HI_LSB       = 16;
   localparam int OFS_COMMIT   = 'h000;
   localparam int OFS_CTRL     = 'h004;
   localparam int OFS_AXIS     = 'h010;
   localparam int AXIS_STRIDE  = 'h008;
   localparam int ACT_DELTA    = 'h004;
   localparam int NUM_AXES     = 2;
   localparam int BIT_COMMIT   = 0;
   localparam int BIT_STANDBY  = 22;
   localparam int POL_HS       = 0;
   localparam int POL_VS       = 1;
   localparam int POL_DE       = 2;
   localparam int POL_CLK      = 3;

   typedef struct packed {
      logic [FIELD_W-1:0] total;
      logic [FIELD_W-1:0] sync;
      logic [FIELD_W-1:0] act_st;
      logic [FIELD_W-1:0] act_end;
   } axis_cfg_t;

   function automatic logic [31:0] pack_fields(logic [FIELD_W-1:0] hi, logic [FIELD_W-1:0] lo);
      return {3'b000, hi, 3'b000, lo};
   endfunction
endpackage

// File: rtl/stg_axis_counter.sv
module stg_axis_counter #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic [CNT_W-1:0] total,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   assign last = (cnt == total - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (adv) cnt <= last ? '0 : cnt + 1'b1;
   end

   AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (total != '0) |-> (cnt < total)); // R1
endmodule

// File: rtl/stg_window.sv
module stg_window #(
   parameter int CNT_W = 13
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] sync_w,
   input  logic [CNT_W-1:0] act_st,
   input  logic [CNT_W-1:0] act_end,
   output logic             in_sync,
   output logic             in_act,
   output logic [CNT_W-1:0] offset
);
   assign in_sync = (cnt < sync_w);
   assign in_act  = (cnt >= act_st) && (cnt < act_end);
   assign offset  = in_act ? (cnt - act_st) : '0;
endmodule

// File: rtl/stg_regs.sv
module stg_regs
   import stg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int H_SYNC_W  = 4,
   parameter int H_TOTAL   = 20,
   parameter int H_ACT_ST  = 6,
   parameter int H_ACT_END = 16,
   parameter int V_SYNC_W  = 2,
   parameter int V_TOTAL   = 8,
   parameter int V_ACT_ST  = 3,
   parameter int V_ACT_END = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic              frame_wrap,
   output axis_cfg_t [NUM_AXES-1:0] live_o,
   output logic              standby_o,
   output logic [3:0]        pol_o,
   output logic              cfg_taken_o
);
   localparam logic [ADDR_W-1:0] A_COMMIT = ADDR_W'(OFS_COMMIT);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam axis_cfg_t DEF_H = '{total: FIELD_W'(H_TOTAL), sync: FIELD_W'(H_SYNC_W),
                                   act_st: FIELD_W'(H_ACT_ST), act_end: FIELD_W'(H_ACT_END)};
   localparam axis_cfg_t DEF_V = '{total: FIELD_W'(V_TOTAL), sync: FIELD_W'(V_SYNC_W),
                                   act_st: FIELD_W'(V_ACT_ST), act_end: FIELD_W'(V_ACT_END)};

   axis_cfg_t [NUM_AXES-1:0] pend_q;
   axis_cfg_t [NUM_AXES-1:0] live_q;
   logic armed_q;
   logic standby_q;
   logic [3:0] pol_q;
   logic taken_q;
   logic commit_wr;
   logic apply;
   logic unused_wr_bits;

   assign unused_wr_bits = ^{wr_data[31:29], wr_data[15:13]};
   assign commit_wr = wr_en && (wr_addr == A_COMMIT) && wr_data[BIT_COMMIT];
   assign apply     = armed_q && (frame_wrap || standby_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= {DEF_V, DEF_H};
         live_q    <= {DEF_V, DEF_H};
         armed_q   <= 1'b0;
         standby_q <= 1'b0;
         pol_q     <= '0;
         taken_q   <= 1'b0;
      end else begin
         if (wr_en) begin
            if (wr_addr == A_CTRL) begin
               standby_q <= wr_data[BIT_STANDBY];
               pol_q     <= wr_data[3:0];
            end
            for (int i = 0; i < NUM_AXES; i++) begin
               if (wr_addr == ADDR_W'(OFS_AXIS + i*AXIS_STRIDE)) begin
                  pend_q[i].sync  <= wr_data[FIELD_W-1:0];
                  pend_q[i].total <= wr_data[HI_LSB +: FIELD_W];
               end
               if (wr_addr == ADDR_W'(OFS_AXIS + i*AXIS_STRIDE + ACT_DELTA)) begin
                  pend_q[i].act_end <= wr_data[FIELD_W-1:0];
                  pend_q[i].act_st  <= wr_data[HI_LSB +: FIELD_W];
               end
            end
         end
         if (apply) live_q <= pend_q;
         if (commit_wr)  armed_q <= 1'b1;
         else if (apply) armed_q <= 1'b0;
         taken_q <= apply;
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_COMMIT) rd_data[BIT_COMMIT] = armed_q;
      if (rd_addr == A_CTRL) begin
         rd_data[BIT_STANDBY] = standby_q;
         rd_data[3:0]         = pol_q;
      end
      for (int i = 0; i < NUM_AXES; i++) begin
         if (rd_addr == ADDR_W'(OFS_AXIS + i*AXIS_STRIDE))
            rd_data = pack_fields(pend_q[i].total, pend_q[i].sync);
         if (rd_addr == ADDR_W'(OFS_AXIS + i*AXIS_STRIDE + ACT_DELTA))
            rd_data = pack_fields(pend_q[i].act_st, pend_q[i].act_end);
      end
   end

   assign live_o      = live_q;
   assign standby_o   = standby_q;
   assign pol_o       = pol_q;
   assign cfg_taken_o = taken_q;

   AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !apply |=> $stable(live_q)); // R4
   AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (apply && !commit_wr) |=> !armed_q); // R5
   AST_TAKEN_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      taken_o_chk |-> $past(armed_q)); // R6

   logic taken_o_chk;
   assign taken_o_chk = taken_q;
endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
   import stg_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int CNT_W     = 13,
   parameter int H_SYNC_W  = 4,
   parameter int H_TOTAL   = 20,
   parameter int H_ACT_ST  = 6,
   parameter int H_ACT_END = 16,
   parameter int V_SYNC_W  = 2,
   parameter int V_TOTAL   = 8,
   parameter int V_ACT_ST  = 3,
   parameter int V_ACT_END = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic              pclk_inv_o,
   output logic [CNT_W-1:0]  pos_x_o,
   output logic [CNT_W-1:0]  pos_y_o,
   output logic              frame_start_o,
   output logic              cfg_taken_o
);
   localparam int MAX_CNT = 2**CNT_W;

   if (CNT_W < 2 || CNT_W > FIELD_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and the 13-bit field width");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("ADDR_W too narrow for the register map");
   end
   if (H_TOTAL < 1 || H_TOTAL >= MAX_CNT || V_TOTAL < 1 || V_TOTAL >= MAX_CNT) begin : g_bad_total
      $error("default totals do not fit the counters");
   end
   if (H_ACT_END > H_TOTAL || V_ACT_END > V_TOTAL || H_ACT_ST > H_ACT_END || V_ACT_ST > V_ACT_END) begin : g_bad_window
      $error("default active window lies outside the total");
   end

   axis_cfg_t [NUM_AXES-1:0] live;
   logic             standby;
   logic [3:0]       pol;
   logic             frame_wrap;
   logic             fs_q;
   logic [NUM_AXES-1:0] ax_last;
   logic [NUM_AXES-1:0] ax_sync;
   logic [NUM_AXES-1:0] ax_act;
   logic [CNT_W-1:0] ax_cnt [NUM_AXES];
   logic [CNT_W-1:0] ax_off [NUM_AXES];
   logic             de_raw;

   stg_regs #(
      .ADDR_W(ADDR_W),
      .H_SYNC_W(H_SYNC_W), .H_TOTAL(H_TOTAL), .H_ACT_ST(H_ACT_ST), .H_ACT_END(H_ACT_END),
      .V_SYNC_W(V_SYNC_W), .V_TOTAL(V_TOTAL), .V_ACT_ST(V_ACT_ST), .V_ACT_END(V_ACT_END)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .frame_wrap(frame_wrap),
      .live_o(live), .standby_o(standby), .pol_o(pol),
      .cfg_taken_o(cfg_taken_o)
   );

   for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      logic adv;
      if (a == 0) begin : g_line
         assign adv = 1'b1;
      end else begin : g_rows
         assign adv = ax_last[a-1];
      end

      stg_axis_counter #(.CNT_W(CNT_W)) u_cnt (
         .clk(clk), .rst_n(rst_n), .clr(standby), .adv(adv),
         .total(live[a].total[CNT_W-1:0]),
         .cnt(ax_cnt[a]), .last(ax_last[a])
      );

      stg_window #(.CNT_W(CNT_W)) u_win (
         .cnt(ax_cnt[a]),
         .sync_w(live[a].sync[CNT_W-1:0]),
         .act_st(live[a].act_st[CNT_W-1:0]),
         .act_end(live[a].act_end[CNT_W-1:0]),
         .in_sync(ax_sync[a]), .in_act(ax_act[a]), .offset(ax_off[a])
      );
   end

   assign frame_wrap = ax_last[0] & ax_last[1] & ~standby;
   assign de_raw     = ax_act[0] & ax_act[1] & ~standby;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fs_q <= 1'b0;
      else        fs_q <= frame_wrap;
   end

   assign hsync_o       = (ax_sync[0] & ~standby) ^ pol[POL_HS];
   assign vsync_o       = (ax_sync[1] & ~standby) ^ pol[POL_VS];
   assign de_o          = de_raw ^ pol[POL_DE];
   assign pclk_inv_o    = pol[POL_CLK];
   assign pos_x_o       = de_raw ? ax_off[0] : '0;
   assign pos_y_o       = de_raw ? ax_off[1] : '0;
   assign frame_start_o = fs_q;

   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      standby |-> (hsync_o == pol[POL_HS] && vsync_o == pol[POL_VS] && de_o == pol[POL_DE]
                   && pos_x_o == '0 && pos_y_o == '0)); // R9
   AST_FRAME_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |-> (ax_cnt[0] == '0 && ax_cnt[1] == '0)); // R7
   AST_FRAME_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start_o |=> !frame_start_o); // R7
endmodule

// File: tb/sync_timing_gen_bench.sv
module sync_timing_gen_bench;
   localparam int AW = 12;
   localparam int CW = 13;
   localparam int HS = 4, HT = 20, HST = 6, HEN = 16;
   localparam int VS = 2, VT = 8, VST = 3, VEN = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic hsync_o, vsync_o, de_o, pclk_inv_o, frame_start_o, cfg_taken_o;
   logic [CW-1:0] pos_x_o, pos_y_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   int m_h, m_v, m_pend, m_stby, m_pol, e_fs, e_ct;
   int l_sync[2], l_tot[2], l_st[2], l_end[2];
   int p_sync[2], p_tot[2], p_st[2], p_end[2];

   always #4 clk = ~clk;

   sync_timing_gen #(
      .ADDR_W(AW), .CNT_W(CW),
      .H_SYNC_W(HS), .H_TOTAL(HT), .H_ACT_ST(HST), .H_ACT_END(HEN),
      .V_SYNC_W(VS), .V_TOTAL(VT), .V_ACT_ST(VST), .V_ACT_END(VEN)
   ) u_sync_timing_gen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .de_o(de_o), .pclk_inv_o(pclk_inv_o), .pos_x_o(pos_x_o), .pos_y_o(pos_y_o),
      .frame_start_o(frame_start_o), .cfg_taken_o(cfg_taken_o)
   );

   function automatic logic [31:0] pk(int hi, int lo);
      return {3'b000, 13'(hi), 3'b000, 13'(lo)};
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d (h=%0d v=%0d)", req, what, act, exp, m_h, m_v);
      end
   endtask

   task automatic model_reset();
      m_h = 0; m_v = 0; m_pend = 0; m_stby = 0; m_pol = 0; e_fs = 0; e_ct = 0;
      l_sync[0] = HS; l_tot[0] = HT; l_st[0] = HST; l_end[0] = HEN;
      l_sync[1] = VS; l_tot[1] = VT; l_st[1] = VST; l_end[1] = VEN;
      for (int i = 0; i < 2; i++) begin
         p_sync[i] = l_sync[i]; p_tot[i] = l_tot[i]; p_st[i] = l_st[i]; p_end[i] = l_end[i];
      end
   endtask

   // Advance one clock edge; the model follows the requirements.
   task automatic step();
      int nh, nv;
      bit hl, vl, wrap, apply;
      hl = (m_h == l_tot[0] - 1);
      vl = (m_v == l_tot[1] - 1);
      wrap  = (m_stby == 0) && hl && vl;
      apply = (m_pend != 0) && (wrap || m_stby != 0);
      nh = (m_stby != 0) ? 0 : (hl ? 0 : m_h + 1);
      nv = (m_stby != 0) ? 0 : (hl ? (vl ? 0 : m_v + 1) : m_v);
      @(negedge clk);
      if (apply) begin
         for (int i = 0; i < 2; i++) begin
            l_sync[i] = p_sync[i]; l_tot[i] = p_tot[i]; l_st[i] = p_st[i]; l_end[i] = p_end[i];
         end
      end
      if (wr_en && wr_addr == 0 && wr_data[0]) m_pend = 1;
      else if (apply) m_pend = 0;
      if (wr_en) begin
         if (wr_addr == 'h004) begin
            m_stby = int'(wr_data[22]);
            m_pol  = int'(wr_data[3:0]);
         end
         for (int i = 0; i < 2; i++) begin
            if (wr_addr == AW'('h010 + 8*i)) begin
               p_sync[i] = int'(wr_data[12:0]); p_tot[i] = int'(wr_data[28:16]);
            end
            if (wr_addr == AW'('h014 + 8*i)) begin
               p_end[i] = int'(wr_data[12:0]); p_st[i] = int'(wr_data[28:16]);
            end
         end
      end
      m_h = nh; m_v = nv; e_fs = int'(wrap); e_ct = int'(apply);
   endtask

   task automatic check_outputs();
      int hs, vs, de;
      hs = (m_stby == 0 && m_h < l_sync[0]) ? 1 : 0;
      vs = (m_stby == 0 && m_v < l_sync[1]) ? 1 : 0;
      de = (m_stby == 0 && m_h >= l_st[0] && m_h < l_end[0] && m_v >= l_st[1] && m_v < l_end[1]) ? 1 : 0;
      chk("R2", "hsync", int'(hsync_o), hs ^ (m_pol & 1));
      chk("R2", "vsync", int'(vsync_o), vs ^ ((m_pol >> 1) & 1));
      chk("R3", "de", int'(de_o), de ^ ((m_pol >> 2) & 1));
      chk("R3", "pos_x", int'(pos_x_o), de ? m_h - l_st[0] : 0);
      chk("R3", "pos_y", int'(pos_y_o), de ? m_v - l_st[1] : 0);
      chk("R7", "frame_start", int'(frame_start_o), e_fs);
      chk("R6", "cfg_taken", int'(cfg_taken_o), e_ct);
      chk("R8", "pclk_inv", int'(pclk_inv_o), (m_pol >> 3) & 1);
   endtask

   task automatic run(int n);
      for (int k = 0; k < n; k++) begin
         step();
         check_outputs();
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      step();
      check_outputs();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string req, int a, int exp);
      rd_addr = AW'(a);
      #1;
      chk(req, "rd_data", int'(rd_data), exp);
   endtask

   task automatic t_reset();
      chk("R1", "hsync at reset", int'(hsync_o), 1);
      chk("R1", "vsync at reset", int'(vsync_o), 1);
      chk("R1", "de at reset", int'(de_o), 0);
      chk("R1", "frame_start at reset", int'(frame_start_o), 0);
      check_outputs();
      rd_chk("R5", 'h000, 0);
      rd_chk("R4", 'h010, int'(pk(HT, HS)));
      rd_chk("R4", 'h01C, int'(pk(VST, VEN)));
   endtask

   task automatic t_default_frames();
      int gap = 0;
      int seen = 0;
      for (int k = 0; k < 2*HT*VT + 4; k++) begin
         step();
         check_outputs();
         gap++;
         if (frame_start_o) begin
            if (seen > 0) chk("R1", "frame length", gap, HT*VT);
            seen++;
            gap = 0;
         end
      end
      chk("R7", "frame pulses in two frames", seen, 2);
   endtask

   task automatic t_pending_only();
      wr('h010, pk(14, 3));
      wr('h014, pk(5, 12));
      wr('h018, pk(6, 1));
      wr('h01C, pk(2, 5));
      rd_chk("R4", 'h010, int'(pk(14, 3)));
      rd_chk("R4", 'h014, int'(pk(5, 12)));
      rd_chk("R4", 'h018, int'(pk(6, 1)));
      rd_chk("R4", 'h01C, int'(pk(2, 5)));
      run(3*HT + 7);
   endtask

   task automatic t_commit();
      int guard = 0;
      wr('h000, 32'h1);
      rd_chk("R5", 'h000, 1);
      run(5);
      rd_chk("R5", 'h000, 1);
      while (m_pend != 0 && guard < 400) begin
         step(); check_outputs(); guard++;
      end
      chk("R6", "cfg_taken when new frame begins", int'(cfg_taken_o), 1);
      chk("R5", "counters at origin", int'(hsync_o), 1);
      rd_chk("R5", 'h000, 0);
      run(2*14*6 + 3);
   endtask

   task automatic t_polarity();
      wr('h004, 32'hF);
      run(14*6);
      chk("R8", "pclk_inv set", int'(pclk_inv_o), 1);
      wr('h004, 32'h2);
      run(30);
   endtask

   task automatic t_standby();
      logic [31:0] c;
      c = (32'h1 << 22) | 32'h5;
      wr('h004, c);
      run(25);
      chk("R9", "hsync idle", int'(hsync_o), 1);
      chk("R9", "vsync idle", int'(vsync_o), 0);
      chk("R9", "de idle", int'(de_o), 1);
      chk("R9", "frame_start idle", int'(frame_start_o), 0);
      rd_chk("R9", 'h004, int'(c));
      wr('h018, pk(7, 2));
      wr('h01C, pk(3, 6));
      wr('h000, 32'h1);
      step(); check_outputs();
      chk("R10", "cfg_taken one edge after commit", int'(cfg_taken_o), 1);
      rd_chk("R10", 'h000, 0);
      wr('h004, 32'h0);
      step(); check_outputs();
      chk("R9", "hsync after resume", int'(hsync_o), 1);
      run(2*14*7 + 5);
   endtask

   task automatic t_ignored();
      wr('h000, 32'h0);
      rd_chk("R11", 'h000, 0);
      wr('h00C, 32'hFFFF_FFFF);
      wr('h020, 32'hFFFF_FFFF);
      wr('h100, 32'hFFFF_FFFF);
      rd_chk("R11", 'h004, 0);
      rd_chk("R11", 'h010, int'(pk(14, 3)));
      rd_chk("R11", 'h018, int'(pk(7, 2)));
      rd_chk("R11", 'h01C, int'(pk(3, 6)));
      run(14*7 + 3);
      chk("R11", "no commit armed", m_pend, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_default_frames();
      t_pending_only();
      t_commit();
      t_polarity();
      t_standby();
      t_ignored();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule